// File: doc/BRIEF.md
# CAN Error Status Register Bank

This block keeps the error bookkeeping of a CAN controller in a small byte-wide register bank. It holds a transmit error counter, a receive error counter, a programmable warning threshold, a capture register for the most recent bus error and a capture register for the identifier bit at which arbitration was lost. The CAN protocol engine does not touch the registers directly. It sends single-cycle event pulses: count up or down, bus-off entry, bus error with its code and frame state, and arbitration loss with its bit position. The bank turns these into register state, two sticky status flags and a warning level.

A host reaches the bank through a simple bus. The bus uses an address within the bank, a write strobe, a read strobe, write data and combinational read data. Reading a capture register has a side effect: the read clears the matching flag and arms the register for the next event. The host can load the counters only while the protocol engine is held in reset mode. The warning threshold can be written at any time. The warning output compares both counters against the threshold on every cycle.

Top module: `can_err_bank`

## Requirements
- R1: After a synchronous active-low reset, both counters read 00h, the warning threshold reads 96h, both capture registers read 00h, both flags are 0 and the warning output is 0.
- R2: A host write to the transmit counter (offset 274h) or the receive counter (offset 275h) is accepted only while `core_reset_mode` is 1. In any other cycle the write leaves the counter unchanged.
- R3: A `bus_off` pulse loads the transmit counter with 128 and clears the receive counter in the next cycle. This has priority over host writes and count events in the same cycle.
- R4: An increment pulse raises a counter by one and stops at 255. A decrement pulse lowers it by one and stops at 0. Increment and decrement together leave it unchanged.
- R5: The warning threshold (offset 276h) accepts a host write in any mode and reads back the written byte.
- R6: `err_warn` is 1 exactly when the transmit counter or the receive counter is greater than or equal to the warning threshold.
- R7: A bus error captured while armed stores the code in bits 7:6 and the frame state in bits 5:0 of offset 278h, and `berr_flag` reads 1 from the next cycle.
- R8: While `berr_flag` is 1, further bus errors are ignored. A host read of 278h returns the held value, clears the flag and rearms capture. A bus error in the same cycle as that read is captured, so the flag stays 1 and the next read returns the new error.
- R9: An arbitration loss captured while armed stores the bit number in bits 4:0 of offset 27Ah, with the upper bits at 0, and `arblst_flag` reads 1 from the next cycle.
- R10: While `arblst_flag` is 1, further arbitration losses are ignored. A host read of 27Ah clears the flag and rearms capture. An arbitration loss in the same cycle as that read is captured.
- R11: Reads of unmapped offsets return 00h. Host writes to the two capture offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 10 | Byte offset within the bank |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; a read of a capture offset rearms that register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for `host_addr` |
| core_reset_mode | input | 1 | Protocol engine is in reset mode; enables counter writes |
| tx_inc | input | 1 | Transmit counter increment pulse |
| tx_dec | input | 1 | Transmit counter decrement pulse |
| rx_inc | input | 1 | Receive counter increment pulse |
| rx_dec | input | 1 | Receive counter decrement pulse |
| bus_off | input | 1 | Bus-off entry pulse |
| berr_evt | input | 1 | Bus error pulse |
| berr_code | input | 2 | Bus error code |
| berr_state | input | 6 | Frame state at the bus error |
| arb_lost_evt | input | 1 | Arbitration-lost pulse |
| arb_bit | input | 5 | Identifier bit number where arbitration was lost |
| berr_flag | output | 1 | Bus error captured and not yet read |
| arblst_flag | output | 1 | Arbitration loss captured and not yet read |
| err_warn | output | 1 | Some counter is at or above the threshold |

## Verification
The bench uses the default build: 8-bit counters, a 10-bit offset space and a 5-bit arbitration field. At 8 bits the full counter range is small enough to walk step by step, so both saturation points and every threshold value from 0 to 255 are covered by sweeps. Each sweep compares against a value the bench works out arithmetically. The capture tests include a host read and a new event landing in the same cycle, and bus-off arriving together with a counter write.

// File: rtl/can_err_pkg.sv
// Shared types for the CAN error register bank.
// Assumes byte-wide host access; register select is decoded once in the top.
package can_err_pkg;
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TXC,
        SEL_RXC,
        SEL_EWL,
        SEL_ECC,
        SEL_ALC
    } reg_sel_e;
endpackage

// File: rtl/can_err_counter.sv
// Saturating error counter with host load and bus-off preset.
// Priority: bus-off preset, then an allowed host write, then count events.
// Assumes event inputs are single-cycle pulses from the protocol engine.
module can_err_counter #(
    parameter int W          = 8,
    parameter int BUSOFF_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         bus_off,
    input  logic         wr_req,
    input  logic         wr_allow,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] BOV  = W'(BUSOFF_VAL);

    logic [W-1:0] nxt;

    // Next-value selection with saturation at both ends.
    always_comb begin
        nxt = q;
        if (bus_off)
            nxt = BOV;
        else if (wr_req && wr_allow)
            nxt = wdata;
        else if (inc && !dec && q != MAXV)
            nxt = q + 1'b1;
        else if (dec && !inc && q != '0)
            nxt = q - 1'b1;
    end

    // Counter state register.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R3
    busoff_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |=> q == BOV);
    // R2
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_allow && !inc && !dec && !bus_off) |=> $stable(q));
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q == MAXV && inc && !bus_off && !(wr_req && wr_allow)) |=> q == MAXV);
    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q == '0 && dec && !bus_off && !(wr_req && wr_allow)) |=> q == '0);
endmodule

// File: rtl/can_err_capture.sv
// Freeze-on-first capture register with a sticky flag.
// The first event while armed is stored and raises the flag. Later events are
// dropped until a host read (rd_ack) clears the flag. An event in the read
// cycle is captured at once. Assumes rd_ack is already address-decoded.
module can_err_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic [W-1:0] evt_data,
    input  logic         rd_ack,
    output logic         flag,
    output logic [W-1:0] data
);
    logic take;

    // Capture is allowed when armed or when the current read rearms it.
    always_comb take = evt && (!flag || rd_ack);

    // Flag and captured value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            data <= '0;
        end else begin
            if (take) begin
                flag <= 1'b1;
                data <= evt_data;
            end else if (rd_ack) begin
                flag <= 1'b0;
            end
        end
    end

    // R8 R10
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd_ack) |=> (flag && $stable(data)));
    // R8 R10
    read_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !evt) |=> !flag);
    // R7 R9
    capture_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !flag) |=> (flag && data == $past(evt_data)));
endmodule

// File: rtl/can_err_bank.sv
// CAN error status register bank: two error counters, a warning threshold,
// a bus-error capture register and an arbitration-lost capture register.
// Host reads are combinational. A read strobe on a capture offset rearms that
// register at the clock edge. Assumes event inputs are single-cycle pulses.
module can_err_bank #(
    parameter int                ADDR_W  = 10,
    parameter int                CNT_W   = 8,
    parameter int                ARB_W   = 5,
    parameter int                EWL_RST = 150,
    parameter logic [ADDR_W-1:0] OFS_TXC = 10'h274,
    parameter logic [ADDR_W-1:0] OFS_RXC = 10'h275,
    parameter logic [ADDR_W-1:0] OFS_EWL = 10'h276,
    parameter logic [ADDR_W-1:0] OFS_ECC = 10'h278,
    parameter logic [ADDR_W-1:0] OFS_ALC = 10'h27A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [CNT_W-1:0]  host_wdata,
    output logic [CNT_W-1:0]  host_rdata,
    input  logic              core_reset_mode,
    input  logic              tx_inc,
    input  logic              tx_dec,
    input  logic              rx_inc,
    input  logic              rx_dec,
    input  logic              bus_off,
    input  logic              berr_evt,
    input  logic [1:0]        berr_code,
    input  logic [CNT_W-3:0]  berr_state,
    input  logic              arb_lost_evt,
    input  logic [ARB_W-1:0]  arb_bit,
    output logic              berr_flag,
    output logic              arblst_flag,
    output logic              err_warn
);
    import can_err_pkg::*;

    localparam int TX_BUSOFF = 1 << (CNT_W - 1);

    reg_sel_e         sel;
    logic [CNT_W-1:0] txc, rxc, ewl, ecc;
    logic [ARB_W-1:0] alc;

    // Offset decode.
    always_comb begin
        if      (host_addr == OFS_TXC) sel = SEL_TXC;
        else if (host_addr == OFS_RXC) sel = SEL_RXC;
        else if (host_addr == OFS_EWL) sel = SEL_EWL;
        else if (host_addr == OFS_ECC) sel = SEL_ECC;
        else if (host_addr == OFS_ALC) sel = SEL_ALC;
        else                           sel = SEL_NONE;
    end

    can_err_counter #(.W(CNT_W), .BUSOFF_VAL(TX_BUSOFF)) u_txc (
        .clk(clk), .rst_n(rst_n), .inc(tx_inc), .dec(tx_dec), .bus_off(bus_off),
        .wr_req(host_wr && sel == SEL_TXC), .wr_allow(core_reset_mode),
        .wdata(host_wdata), .q(txc));

    can_err_counter #(.W(CNT_W), .BUSOFF_VAL(0)) u_rxc (
        .clk(clk), .rst_n(rst_n), .inc(rx_inc), .dec(rx_dec), .bus_off(bus_off),
        .wr_req(host_wr && sel == SEL_RXC), .wr_allow(core_reset_mode),
        .wdata(host_wdata), .q(rxc));

    // Warning threshold register, writable in any mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ewl <= CNT_W'(EWL_RST);
        else if (host_wr && sel == SEL_EWL) ewl <= host_wdata;
    end

    can_err_capture #(.W(CNT_W)) u_ecc (
        .clk(clk), .rst_n(rst_n), .evt(berr_evt),
        .evt_data({berr_code, berr_state}),
        .rd_ack(host_rd && sel == SEL_ECC), .flag(berr_flag), .data(ecc));

    can_err_capture #(.W(ARB_W)) u_alc (
        .clk(clk), .rst_n(rst_n), .evt(arb_lost_evt), .evt_data(arb_bit),
        .rd_ack(host_rd && sel == SEL_ALC), .flag(arblst_flag), .data(alc));

    // Threshold compare, re-evaluated every cycle.
    always_comb err_warn = (txc >= ewl) || (rxc >= ewl);

    // Read data multiplexer.
    always_comb begin
        case (sel)
            SEL_TXC: host_rdata = txc;
            SEL_RXC: host_rdata = rxc;
            SEL_EWL: host_rdata = ewl;
            SEL_ECC: host_rdata = ecc;
            SEL_ALC: host_rdata = CNT_W'(alc);
            default: host_rdata = '0;
        endcase
    end

    // R5
    ewl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_EWL) |=> ewl == $past(host_wdata));
    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> host_rdata == '0);
endmodule

// File: tb/can_err_bank_tb.sv
module can_err_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       core_reset_mode = 1'b1;
    logic       tx_inc = 0, tx_dec = 0, rx_inc = 0, rx_dec = 0, bus_off = 0;
    logic       berr_evt = 0;
    logic [1:0] berr_code = '0;
    logic [5:0] berr_state = '0;
    logic       arb_lost_evt = 0;
    logic [4:0] arb_bit = '0;
    logic       berr_flag, arblst_flag, err_warn;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;  // 50 MHz

    can_err_bank u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_reset_mode(core_reset_mode), .tx_inc(tx_inc), .tx_dec(tx_dec),
        .rx_inc(rx_inc), .rx_dec(rx_dec), .bus_off(bus_off),
        .berr_evt(berr_evt), .berr_code(berr_code), .berr_state(berr_state),
        .arb_lost_evt(arb_lost_evt), .arb_bit(arb_bit),
        .berr_flag(berr_flag), .arblst_flag(arblst_flag), .err_warn(err_warn));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        step();
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        step();
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(10'h274, d); chk("R1 txc", d, 0);
        rd(10'h275, d); chk("R1 rxc", d, 0);
        rd(10'h276, d); chk("R1 ewl", d, 8'h96);
        rd(10'h278, d); chk("R1 ecc", d, 0);
        rd(10'h27A, d); chk("R1 alc", d, 0);
        chk("R1 berr_flag", berr_flag, 0);
        chk("R1 arblst_flag", arblst_flag, 0);
        chk("R1 warn", err_warn, 0);

        // R11 unmapped offsets
        rd(10'h277, d); chk("R11 unmapped 277", d, 0);
        rd(10'h000, d); chk("R11 unmapped 000", d, 0);

        // R2 writes only in reset mode
        wr(10'h274, 8'h55); rd(10'h274, d); chk("R2 tx write", d, 8'h55);
        wr(10'h275, 8'h33); rd(10'h275, d); chk("R2 rx write", d, 8'h33);
        core_reset_mode = 1'b0;
        wr(10'h274, 8'h11); rd(10'h274, d); chk("R2 tx blocked", d, 8'h55);
        wr(10'h275, 8'h22); rd(10'h275, d); chk("R2 rx blocked", d, 8'h33);

        // R3 bus-off
        bus_off = 1'b1; step(); bus_off = 1'b0;
        rd(10'h274, d); chk("R3 tx preset", d, 128);
        rd(10'h275, d); chk("R3 rx cleared", d, 0);
        core_reset_mode = 1'b1;
        host_addr = 10'h274; host_wdata = 8'h07; host_wr = 1'b1; bus_off = 1'b1;
        rx_inc = 1'b1;
        step();
        host_wr = 1'b0; bus_off = 1'b0; rx_inc = 1'b0;
        rd(10'h274, d); chk("R3 priority tx", d, 128);
        rd(10'h275, d); chk("R3 priority rx", d, 0);

        // R4 saturating sweeps
        wr(10'h274, 8'h00);
        core_reset_mode = 1'b0;
        for (int i = 1; i <= 300; i++) begin
            tx_inc = 1'b1; step(); tx_inc = 1'b0;
            exp = (i > 255) ? 255 : i;
            rd(10'h274, d); chk("R4 tx inc", d, exp);
        end
        tx_inc = 1'b1; tx_dec = 1'b1; step(); tx_inc = 1'b0; tx_dec = 1'b0;
        rd(10'h274, d); chk("R4 inc+dec", d, 255);
        for (int i = 1; i <= 300; i++) begin
            tx_dec = 1'b1; step(); tx_dec = 1'b0;
            exp = (255 - i < 0) ? 0 : 255 - i;
            rd(10'h274, d); chk("R4 tx dec", d, exp);
        end
        for (int i = 1; i <= 4; i++) begin
            rx_dec = 1'b1; step(); rx_dec = 1'b0;
        end
        rd(10'h275, d); chk("R4 rx floor", d, 0);
        for (int i = 1; i <= 260; i++) begin
            rx_inc = 1'b1; step(); rx_inc = 1'b0;
        end
        rd(10'h275, d); chk("R4 rx ceiling", d, 255);

        // R5 R6 threshold sweep with tx=100, rx=0
        core_reset_mode = 1'b1;
        wr(10'h274, 8'd100); wr(10'h275, 8'd0);
        core_reset_mode = 1'b0;
        for (int e = 0; e < 256; e++) begin
            wr(10'h276, 8'(e));
            rd(10'h276, d); chk("R5 ewl readback", d, e);
            chk("R6 warn tx", err_warn, (100 >= e) ? 1 : 0);
        end
        core_reset_mode = 1'b1;
        wr(10'h274, 8'd0); wr(10'h275, 8'd200);
        wr(10'h276, 8'd200); chk("R6 warn rx eq", err_warn, 1);
        wr(10'h276, 8'd201); chk("R6 warn rx below", err_warn, 0);

        // R7 R8 bus error capture
        berr_evt = 1; berr_code = 2'd2; berr_state = 6'h15; step(); berr_evt = 0;
        chk("R7 berr_flag set", berr_flag, 1);
        berr_evt = 1; berr_code = 2'd1; berr_state = 6'h03; step(); berr_evt = 0;
        wr(10'h278, 8'hFF);  // R11 write to capture ignored
        rd(10'h278, d); chk("R8 frozen value", d, 8'h95);
        chk("R8 flag cleared", berr_flag, 0);
        berr_evt = 1; berr_code = 2'd3; berr_state = 6'h2A; step(); berr_evt = 0;
        chk("R7 rearmed flag", berr_flag, 1);
        host_addr = 10'h278; host_rd = 1;
        berr_evt = 1; berr_code = 2'd0; berr_state = 6'h07;
        #1 chk("R8 read old", host_rdata, 8'hEA);
        step(); host_rd = 0; berr_evt = 0;
        chk("R8 same-cycle flag", berr_flag, 1);
        rd(10'h278, d); chk("R8 same-cycle value", d, 8'h07);
        chk("R8 flag clear", berr_flag, 0);

        // R9 R10 arbitration-lost capture
        arb_lost_evt = 1; arb_bit = 5'd17; step(); arb_lost_evt = 0;
        chk("R9 arblst set", arblst_flag, 1);
        arb_lost_evt = 1; arb_bit = 5'd4; step(); arb_lost_evt = 0;
        wr(10'h27A, 8'hFF);  // R11
        rd(10'h27A, d); chk("R10 frozen value", d, 17);
        chk("R10 flag cleared", arblst_flag, 0);
        arb_lost_evt = 1; arb_bit = 5'd31; step(); arb_lost_evt = 0;
        host_addr = 10'h27A; host_rd = 1; arb_lost_evt = 1; arb_bit = 5'd9;
        #1 chk("R10 read old", host_rdata, 31);
        step(); host_rd = 0; arb_lost_evt = 0;
        chk("R10 same-cycle flag", arblst_flag, 1);
        rd(10'h27A, d); chk("R9 value upper zero", d, 9);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule